// File: doc/BRIEF.md
# Branch Trace Capture Unit

This unit keeps a record of the most recent break in sequential program flow, for use by a debugger. A control bit turns it on. While it is on, each taken branch instruction, hardware repeat loopback or interrupt entry loads two registers. The destination register receives the address the program went to. The source register receives the current fetch address and a small backward pointer. The pointer counts the instructions that were fetched but not yet executed. Because instructions are 16 bits wide, the last instruction executed before the discontinuity lies at the stored address minus twice the pointer.

There is one exception. For a delayed branch whose target is halfword-odd within a word (address 4n+2), the source register records the target itself. The pointer is then meaningless. Fetch addresses are always word aligned, so a stored source address with bit 1 set can only come from this case. A combinational helper uses that bit. It reports the recovered address, or it raises an invalid flag. The registers hold their contents when there is no event and while tracing is disabled.

Top module: `brtrace_unit`

## Requirements
- R1: A synchronous active-low reset sets the source address, pointer and destination registers to zero.
- R2: Nothing is captured while `trace_en` is 0, and all three registers keep their values.
- R3: `evt_kind` encodes 2'b00 no event, 2'b01 branch instruction, 2'b10 repeat loopback, 2'b11 interrupt. Each non-zero code captures on the clock edge at which it is sampled with `trace_en` at 1.
- R4: A cycle with `evt_kind` 2'b00 leaves all three registers unchanged.
- R5: On every capture, `dst_addr_q` becomes `target_addr`.
- R6: On a normal capture, `src_addr_q` becomes `fetch_addr` with bits [1:0] forced to zero, and `src_ptr_q` becomes `pend_cnt`.
- R7: The special case is `evt_kind` 2'b01 with `delay_slot` 1 and `target_addr[1:0]` 2'b10. In that case `src_addr_q` becomes `target_addr` and `src_ptr_q` becomes 0. For repeat and interrupt events, `delay_slot` has no effect.
- R8: When `src_addr_q[1]` is 0, `recov_invalid` is 0 and `recov_addr` equals `src_addr_q` - 2*`src_ptr_q` (modulo 2^32), in the same cycle.
- R9: When `src_addr_q[1]` is 1, `recov_invalid` is 1 and `recov_addr` is zero.
- R10: A delayed branch to a word-aligned target (`target_addr[1:0]` 2'b00) is a normal capture under R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trace_en | input | 1 | Trace enable control bit |
| fetch_addr | input | 32 | Address of the most recent instruction fetch |
| pend_cnt | input | 2 | Instructions fetched but not yet executed |
| evt_kind | input | 2 | Discontinuity type (R3 encoding) |
| delay_slot | input | 1 | Branch has a delay slot |
| target_addr | input | 32 | Branch destination address |
| src_addr_q | output | 32 | Stored source address |
| src_ptr_q | output | 2 | Stored backward pointer |
| dst_addr_q | output | 32 | Stored destination address |
| recov_addr | output | 32 | Recovered last-executed address |
| recov_invalid | output | 1 | Recovered address cannot be computed |

## Verification
The registers update on the clock edge that samples an event. The bench therefore applies each stimulus on a falling edge and waits one rising edge. It compares the register outputs on the next falling edge, before new inputs go on. The recovery outputs depend only on the registers, so they are due in that same cycle and are checked at the same falling edge. A reference model inside the bench is updated only at the rising edge, so every comparison counts exactly one register stage.

// File: rtl/brtrace_pkg.sv
// Package: shared widths and the discontinuity event encoding for the
// branch trace capture unit. Assumes 16-bit instructions and word fetches.
package brtrace_pkg;
    localparam int ADDR_W = 32;
    localparam int PTR_W  = 2;
    localparam int ALIGN_BITS = 2;   // fetches are word aligned

    typedef enum logic [1:0] {
        EVK_NONE   = 2'b00,
        EVK_BRANCH = 2'b01,
        EVK_REPEAT = 2'b10,
        EVK_IRQ    = 2'b11
    } evt_kind_e;
endpackage

// File: rtl/brtrace_classify.sv
// Module: decides whether this cycle captures and whether the capture is
// the delayed-branch-to-halfword-odd-target special case.
// Assumes evt_kind is valid for exactly the cycle of the discontinuity.
module brtrace_classify
    import brtrace_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          trace_en,
    input  evt_kind_e     kind,
    input  logic          delay_slot,
    input  logic [AW-1:0] target_addr,
    output logic          cap_o,
    output logic          special_o
);
    logic odd_half;

    // Purpose: qualify the event with the enable and detect the special case.
    always_comb begin
        odd_half  = (target_addr[1:0] == 2'b10);
        cap_o     = trace_en && (kind != EVK_NONE);
        special_o = cap_o && (kind == EVK_BRANCH) && delay_slot && odd_half;
    end
endmodule

// File: rtl/brtrace_store.sv
// Module: the source (address + pointer) and destination registers.
// Loads on cap, holds otherwise. Assumes the fetch address low bits are
// don't-care, and clears them so a set bit 1 marks only the special case.
module brtrace_store
    import brtrace_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PTR_W,
    parameter int LB = ALIGN_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic          special,
    input  logic [AW-1:0] fetch_addr,
    input  logic [PW-1:0] pend_cnt,
    input  logic [AW-1:0] target_addr,
    output logic [AW-1:0] src_addr_q,
    output logic [PW-1:0] src_ptr_q,
    output logic [AW-1:0] dst_addr_q
);
    localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << LB) - AW'(1));

    logic [AW-1:0] src_next;
    logic [PW-1:0] ptr_next;

    // Purpose: choose what the source register records for this capture.
    always_comb begin
        if (special) begin
            src_next = target_addr;
            ptr_next = '0;
        end else begin
            src_next = fetch_addr & ALIGN_MASK;
            ptr_next = pend_cnt;
        end
    end

    // Purpose: source register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_addr_q <= '0;
            src_ptr_q  <= '0;
        end else if (cap) begin
            src_addr_q <= src_next;
            src_ptr_q  <= ptr_next;
        end
    end

    // Purpose: destination register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   dst_addr_q <= '0;
        else if (cap) dst_addr_q <= target_addr;
    end

    // R4: no capture leaves every register unchanged.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> ($stable(src_addr_q) && $stable(src_ptr_q) && $stable(dst_addr_q)));
    // R5: the destination takes the target on capture.
    a_r5_dst: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> dst_addr_q == $past(target_addr));
    // R7: the special case records the target and a zero pointer.
    a_r7_special: assert property (@(posedge clk) disable iff (!rst_n)
        special |=> (src_addr_q == $past(target_addr) && src_ptr_q == '0));
    // R6: a normal capture stores a word-aligned source and the pointer.
    a_r6_align: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !special) |=> (src_addr_q[1:0] == 2'b00 && src_ptr_q == $past(pend_cnt)));
endmodule

// File: rtl/brtrace_recover.sv
// Module: combinational helper that rebuilds the last executed address as
// source minus twice the pointer. Assumes bit 1 of the stored source is set
// only by the special case, and flags that as invalid.
module brtrace_recover
    import brtrace_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PTR_W
) (
    input  logic [AW-1:0] src_addr,
    input  logic [PW-1:0] src_ptr,
    output logic [AW-1:0] recov_addr,
    output logic          recov_invalid
);
    logic [AW-1:0] back_bytes;

    // Purpose: compute the byte offset and the recovered address or invalid.
    always_comb begin
        back_bytes    = AW'(src_ptr) << 1;
        recov_invalid = src_addr[1];
        recov_addr    = recov_invalid ? '0 : (src_addr - back_bytes);
    end
endmodule

// File: rtl/brtrace_unit.sv
// Module: top of the branch trace capture unit. Classifies each cycle's
// event, stores source/destination, and exposes the recovered address.
// Assumes one event per cycle at most, and 16-bit instructions.
module brtrace_unit
    import brtrace_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PTR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trace_en,
    input  logic [AW-1:0] fetch_addr,
    input  logic [PW-1:0] pend_cnt,
    input  logic [1:0]    evt_kind,
    input  logic          delay_slot,
    input  logic [AW-1:0] target_addr,
    output logic [AW-1:0] src_addr_q,
    output logic [PW-1:0] src_ptr_q,
    output logic [AW-1:0] dst_addr_q,
    output logic [AW-1:0] recov_addr,
    output logic          recov_invalid
);
    evt_kind_e kind;
    logic      cap;
    logic      special;

    // Purpose: type the raw event code.
    always_comb kind = evt_kind_e'(evt_kind);

    brtrace_classify #(.AW(AW)) u_classify (
        .trace_en    (trace_en),
        .kind        (kind),
        .delay_slot  (delay_slot),
        .target_addr (target_addr),
        .cap_o       (cap),
        .special_o   (special)
    );

    brtrace_store #(.AW(AW), .PW(PW), .LB(ALIGN_BITS)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap         (cap),
        .special     (special),
        .fetch_addr  (fetch_addr),
        .pend_cnt    (pend_cnt),
        .target_addr (target_addr),
        .src_addr_q  (src_addr_q),
        .src_ptr_q   (src_ptr_q),
        .dst_addr_q  (dst_addr_q)
    );

    brtrace_recover #(.AW(AW), .PW(PW)) u_recover (
        .src_addr      (src_addr_q),
        .src_ptr       (src_ptr_q),
        .recov_addr    (recov_addr),
        .recov_invalid (recov_invalid)
    );

    // R2: with tracing disabled the registers are frozen.
    a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> ($stable(src_addr_q) && $stable(src_ptr_q) && $stable(dst_addr_q)));
    // R9: an invalid recovery only ever comes with a zero stored pointer.
    a_r9_invalid_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        recov_invalid |-> (src_ptr_q == '0 && recov_addr == '0));
    // R3: any enabled event loads the destination port.
    a_r3_event_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_en && evt_kind != 2'b00) |=> dst_addr_q == $past(target_addr));
endmodule

// File: tb/test_brtrace_unit.sv
// Bench: random and directed stimulus against a model built from the
// requirements; checks on falling edges one rising edge after each stimulus.
module test_brtrace_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trace_en = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [1:0]  pend_cnt = '0;
    logic [1:0]  evt_kind = '0;
    logic        delay_slot = 1'b0;
    logic [31:0] target_addr = '0;
    logic [31:0] src_addr_q, dst_addr_q, recov_addr;
    logic [1:0]  src_ptr_q;
    logic        recov_invalid;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_src = '0, m_dst = '0;
    logic [1:0]  m_ptr = '0;

    brtrace_unit i_brtrace_unit (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .fetch_addr(fetch_addr),
        .pend_cnt(pend_cnt), .evt_kind(evt_kind), .delay_slot(delay_slot),
        .target_addr(target_addr), .src_addr_q(src_addr_q), .src_ptr_q(src_ptr_q),
        .dst_addr_q(dst_addr_q), .recov_addr(recov_addr), .recov_invalid(recov_invalid)
    );

    always #2.5 clk = ~clk;

    function automatic bit is_special(logic [1:0] k, logic ds, logic [31:0] t);
        return (k == 2'b01) && ds && (t[1:0] == 2'b10);
    endfunction

    function automatic logic [31:0] exp_recov(logic [31:0] s, logic [1:0] p);
        return s[1] ? 32'h0 : s - {29'h0, p, 1'b0};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, "src_addr", src_addr_q, m_src);
        chk(req, "src_ptr", {30'h0, src_ptr_q}, {30'h0, m_ptr});
        chk("R5", "dst_addr", dst_addr_q, m_dst);
        if (m_src[1]) begin
            chk("R9", "recov_invalid", {31'h0, recov_invalid}, 32'h1);
            chk("R9", "recov_addr", recov_addr, 32'h0);
        end else begin
            chk("R8", "recov_invalid", {31'h0, recov_invalid}, 32'h0);
            chk("R8", "recov_addr", recov_addr, exp_recov(m_src, m_ptr));
        end
    endtask

    // One stimulus: drive at falling edge, model at rising edge, check next fall.
    task automatic step(string req, logic en, logic [1:0] k, logic ds,
                        logic [31:0] f, logic [1:0] p, logic [31:0] t);
        trace_en = en; evt_kind = k; delay_slot = ds;
        fetch_addr = f; pend_cnt = p; target_addr = t;
        @(posedge clk);
        if (en && k != 2'b00) begin
            m_dst = t;
            if (is_special(k, ds, t)) begin m_src = t; m_ptr = 2'b00; end
            else begin m_src = {f[31:2], 2'b00}; m_ptr = p; end
        end
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        trace_en = 1'b1; evt_kind = 2'b01; target_addr = 32'hDEAD_BEEE;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        // R3: each event kind captures
        step("R3", 1, 2'b01, 0, 32'h0000_1000, 2'd1, 32'h0000_2000);
        step("R3", 1, 2'b10, 0, 32'h0000_1104, 2'd3, 32'h0000_3004);
        step("R3", 1, 2'b11, 0, 32'h0000_1208, 2'd2, 32'h0000_4008);
        // R6: low fetch bits discarded
        step("R6", 1, 2'b01, 0, 32'h0000_5557, 2'd2, 32'h0000_6000);
        // R4: no event holds
        step("R4", 1, 2'b00, 1, 32'hFFFF_FFFC, 2'd3, 32'h1111_1112);
        // R7 special case, then R9 invalid
        step("R7", 1, 2'b01, 1, 32'h0000_7000, 2'd3, 32'h0000_8002);
        // R2: disabled freezes the special record
        step("R2", 0, 2'b11, 1, 32'h0000_9000, 2'd1, 32'h0000_A000);
        // R10: delayed branch to aligned target
        step("R10", 1, 2'b01, 1, 32'h0000_B000, 2'd3, 32'h0000_C000);
        // R7: delay_slot ignored for repeat and interrupt with 4n+2 targets
        step("R7", 1, 2'b10, 1, 32'h0000_D008, 2'd1, 32'h0000_E002);
        step("R7", 1, 2'b11, 1, 32'h0000_D00C, 2'd2, 32'h0000_F00A);
        // R8: wraparound of recovery below zero
        step("R8", 1, 2'b01, 0, 32'h0000_0000, 2'd2, 32'h0000_0100);
        // R1: reset again clears after activity
        rst_n = 1'b0; @(posedge clk); m_src = '0; m_ptr = '0; m_dst = '0;
        @(negedge clk); check_all("R1"); rst_n = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            logic en;
            logic [1:0] k;
            logic ds;
            logic [31:0] f, t;
            string req;
            en = ($urandom % 8) != 0;
            k  = 2'($urandom);
            ds = 1'($urandom);
            f  = $urandom;
            t  = {$urandom, 1'b0};
            t  = {t[31:2], 1'b1, 1'b0} & (($urandom % 2) ? 32'hFFFF_FFFE : 32'hFFFF_FFFC);
            if (!en) req = "R2";
            else if (k == 2'b00) req = "R4";
            else if (is_special(k, ds, t)) req = "R7";
            else if (ds && k == 2'b01) req = "R10";
            else req = "R6";
            step(req, en, k, ds, f, 2'($urandom), t);
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule